// File: doc/BRIEF.md
# Coprocessor-to-Host Mailbox Queue

A 32-bit register-mapped mailbox through which a coprocessor hands words to a host CPU. Channel logic appends words through a push port. The host drains them through a register port, one word per pop read. Storage is a shift-style queue with a parameter depth, set to 8 by default. A pop hands out entry 0, moves every later entry one slot toward the head, and writes a sentinel word (0xFFFFFFFF) into the slot it frees. Reading an empty queue returns that sentinel and leaves the queue as it was.

The host can also look at the head word without removing it, read a status word that carries full and empty flags, and read or write a configuration word. That word holds a "has data" interrupt enable and a "has data" pending flag. The interrupt line is raised when the queue holds data and the enable is set. Only the low 8 bits of the register address take part in decoding. Read data is registered: it appears on `rdata` one clock after the read strobe and holds until the next read.

Top module: `ipc_mbox_queue`

## Requirements
- R1: The status word (offset 0x98) has bit 31 set exactly when the queue holds DEPTH entries, bit 30 set exactly when it holds none, and all other bits 0. The `q_full` and `q_empty` ports follow the same two conditions, and both are recomputed after every push or pop.
- R2: A read at any offset from 0x80 to 0x8F (address bits [1:0] are ignored) on a non-empty queue returns the oldest entry on `rdata` in the next cycle and removes it, so words leave in the order they were pushed.
- R3: A pop read on an empty queue returns 0xFFFFFFFF and leaves the queue empty.
- R4: A read at offset 0x90 returns the head entry without removing it. The queue's flags and contents are unchanged.
- R5: A pop refills the freed slot with 0xFFFFFFFF, so a peek of a queue that has been drained returns 0xFFFFFFFF.
- R6: The config word (offset 0x9C) reads back bit 0 = interrupt enable and bit 4 = pending, with all other bits 0. A write to 0x9C changes only bit 0, which takes the value of `wdata[0]`.
- R7: Pending is 1 exactly when the queue is not empty. `irq` is 1 exactly when pending and enable are both 1.
- R8: After reset the queue is empty, enable is 0, `irq` is 0, status reads 0x40000000, config reads 0, and a peek returns 0xFFFFFFFF.
- R9: Offset 0x94 and every undecoded offset read 0, and writes to them, and to 0x80-0x98, change nothing. Address bits above bit 7 are ignored.
- R10: A pop read and a push in the same cycle are both applied. The pop takes effect first and the new word is then appended. On an empty queue the read returns 0xFFFFFFFF and the pushed word remains queued.
- R11: A push appends `push_data` at the tail. The caller never pushes while `q_full` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address; only bits [7:0] are decoded |
| wdata | input | 32 | Register write data |
| push_en | input | 1 | Append a word from the channel logic |
| push_data | input | 32 | Word to append |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | "Has data" interrupt |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entries |

## Verification
The hardest case to reach is a pop and a push in the same cycle at the queue's edges. On an empty queue the read must still return the sentinel while the pushed word survives. On a queue with DEPTH-1 entries the tail slot must be written after the shift. Directed steps drive the queue to empty, to full and to one below full, then apply the combined strobe. A long seeded random phase biases pushes and pop reads so the fill level keeps crossing both boundaries, and it mixes in peeks, config writes and stray offsets.

// File: rtl/mbq_pkg.sv
package mbq_pkg;

   localparam int unsigned STAT_FULL_BIT  = 31;
   localparam int unsigned STAT_EMPTY_BIT = 30;
   localparam int unsigned CFG_EN_BIT     = 0;
   localparam int unsigned CFG_PEND_BIT   = 4;

   // word index (offset >> 2) of each decoded register
   localparam logic [5:0] WIDX_PEEK   = 6'h24;
   localparam logic [5:0] WIDX_SENDER = 6'h25;
   localparam logic [5:0] WIDX_STAT   = 6'h26;
   localparam logic [5:0] WIDX_CFG    = 6'h27;
   localparam logic [3:0] POP_NIBBLE  = 4'h8;

   typedef enum logic [2:0] {
      REG_POP,
      REG_PEEK,
      REG_SENDER,
      REG_STAT,
      REG_CFG,
      REG_NONE
   } mbq_reg_e;

   function automatic mbq_reg_e mbq_decode(input logic [7:0] ofs);
      mbq_reg_e k;
      if (ofs[7:4] == POP_NIBBLE)           k = REG_POP;
      else if (ofs[7:2] == WIDX_PEEK)       k = REG_PEEK;
      else if (ofs[7:2] == WIDX_SENDER)     k = REG_SENDER;
      else if (ofs[7:2] == WIDX_STAT)       k = REG_STAT;
      else if (ofs[7:2] == WIDX_CFG)        k = REG_CFG;
      else                                  k = REG_NONE;
      return k;
   endfunction

endpackage

// File: rtl/mbq_decode.sv
module mbq_decode
   import mbq_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   output mbq_reg_e          reg_kind,
   output logic              pop_req,
   output logic              cfg_wr
);

   logic [7:0] ofs;

   // only the low byte takes part in decoding
   assign ofs      = reg_addr[7:0];
   assign reg_kind = mbq_decode(ofs);
   assign pop_req  = rd_en && (reg_kind == REG_POP);
   assign cfg_wr   = wr_en && (reg_kind == REG_CFG);

   logic unused_hi;
   assign unused_hi = ^reg_addr[ADDR_W-1:8];

endmodule

// File: rtl/mbq_store.sv
module mbq_store #(
   parameter int unsigned             DATA_W   = 32,
   parameter int unsigned             DEPTH    = 8,
   parameter logic [DATA_W-1:0]       SENTINEL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pop,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] head,
   output logic              full,
   output logic              empty
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic [DATA_W-1:0] slot_q [DEPTH];
   logic [DATA_W-1:0] slot_d [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_mid;
   logic [CNT_W-1:0]  cnt_d;
   logic              pop_eff;
   logic              push_eff;

   // a pop of an empty queue changes nothing
   assign pop_eff  = pop && (cnt_q != '0);
   assign cnt_mid  = pop_eff ? cnt_q - 1'b1 : cnt_q;
   // pop first, then append; caller keeps push off while full
   assign push_eff = push && (cnt_mid != CNT_MAX);
   assign cnt_d    = push_eff ? cnt_mid + 1'b1 : cnt_mid;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [DATA_W-1:0] shifted;
         if (i == DEPTH - 1) begin : g_tail
            // the last slot refills with the sentinel on a pop
            assign shifted = SENTINEL;
         end else begin : g_body
            assign shifted = slot_q[i+1];
         end

         always_comb begin
            slot_d[i] = pop_eff ? shifted : slot_q[i];
            if (push_eff && (cnt_mid == CNT_W'(i))) begin
               slot_d[i] = push_data;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[i] <= SENTINEL;
            else        slot_q[i] <= slot_d[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign head  = slot_q[0];
   assign full  = (cnt_q == CNT_MAX);
   assign empty = (cnt_q == '0);

endmodule

// File: rtl/mbq_cfg.sv
module mbq_cfg (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_wr,
   input  logic cfg_en_bit,
   input  logic empty,
   output logic irq_en,
   output logic pending,
   output logic irq
);

   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (cfg_wr) en_q <= cfg_en_bit;
   end

   assign irq_en  = en_q;
   assign pending = !empty;
   assign irq     = en_q && pending;

endmodule

// File: rtl/ipc_mbox_queue.sv
module ipc_mbox_queue
   import mbq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DEPTH    = 8,
   parameter logic [31:0] SENTINEL = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       wdata,
   input  logic              push_en,
   input  logic [31:0]       push_data,
   output logic [31:0]       rdata,
   output logic              irq,
   output logic              q_full,
   output logic              q_empty
);

   localparam int unsigned DATA_W = 32;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ipc_mbox_queue: DEPTH must be at least 2");
      end
      if (ADDR_W < 9) begin : g_bad_addr
         $error("ipc_mbox_queue: ADDR_W must exceed 8");
      end
   endgenerate

   mbq_reg_e          reg_kind;
   logic              pop_req;
   logic              cfg_wr;
   logic [DATA_W-1:0] head;
   logic              irq_en;
   logic              pending;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] cfg_word;
   logic [DATA_W-1:0] rd_val;

   mbq_decode #(.ADDR_W(ADDR_W)) u_decode (
      .rd_en    (rd_en),
      .wr_en    (wr_en),
      .reg_addr (reg_addr),
      .reg_kind (reg_kind),
      .pop_req  (pop_req),
      .cfg_wr   (cfg_wr)
   );

   mbq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SENTINEL(SENTINEL)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop       (pop_req),
      .push      (push_en),
      .push_data (push_data),
      .head      (head),
      .full      (q_full),
      .empty     (q_empty)
   );

   mbq_cfg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_en_bit (wdata[CFG_EN_BIT]),
      .empty      (q_empty),
      .irq_en     (irq_en),
      .pending    (pending),
      .irq        (irq)
   );

   always_comb begin
      stat_word = '0;
      stat_word[STAT_FULL_BIT]  = q_full;
      stat_word[STAT_EMPTY_BIT] = q_empty;
      cfg_word = '0;
      cfg_word[CFG_EN_BIT]   = irq_en;
      cfg_word[CFG_PEND_BIT] = pending;
   end

   always_comb begin
      unique case (reg_kind)
         REG_POP:  rd_val = q_empty ? SENTINEL : head;
         REG_PEEK: rd_val = head;
         REG_STAT: rd_val = stat_word;
         REG_CFG:  rd_val = cfg_word;
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end

   logic unused_wd;
   assign unused_wd = ^wdata[DATA_W-1:1];

endmodule

// File: rtl/mbq_checker.sv
module mbq_checker #(
   parameter int unsigned ADDR_W   = 16,
   parameter logic [31:0] SENTINEL = 32'hFFFF_FFFF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              push_en,
   input logic [31:0]       rdata,
   input logic              irq,
   input logic              q_full,
   input logic              q_empty
);

   logic rd_pop;
   logic rd_peek;
   logic rd_sender;
   assign rd_pop    = rd_en && (reg_addr[7:4] == 4'h8);
   assign rd_peek   = rd_en && (reg_addr[7:2] == 6'h24);
   assign rd_sender = rd_en && (reg_addr[7:2] == 6'h25);

   AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |-> !q_full); // R11

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_full && q_empty)); // R1

   AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !q_empty); // R7

   AST_EMPTY_POP_SENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pop && q_empty && !push_en) |=> (q_empty && rdata == SENTINEL)); // R3

   AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_peek && !push_en) |=> ($stable(q_empty) && $stable(q_full))); // R4

   AST_SENDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sender |=> (rdata == 32'h0)); // R9

   AST_POP_PUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pop && q_empty && push_en) |=> (!q_empty && rdata == SENTINEL)); // R10

endmodule

bind ipc_mbox_queue mbq_checker #(.ADDR_W(ADDR_W), .SENTINEL(SENTINEL)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .reg_addr (reg_addr),
   .push_en  (push_en),
   .rdata    (rdata),
   .irq      (irq),
   .q_full   (q_full),
   .q_empty  (q_empty)
);

// File: tb/ipc_mbox_queue_tb.sv
module ipc_mbox_queue_tb;

   localparam int          CLK_PERIOD = 10;
   localparam int          ADDR_W     = 16;
   localparam int          DEPTH      = 8;
   localparam logic [31:0] SENT       = 32'hFFFF_FFFF;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              rd_en, wr_en, push_en;
   logic [ADDR_W-1:0] reg_addr;
   logic [31:0]       wdata, push_data;
   logic [31:0]       rdata;
   logic              irq, q_full, q_empty;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] mq[$];
   logic        m_en;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipc_mbox_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SENTINEL(SENT)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
      .reg_addr(reg_addr), .wdata(wdata), .push_en(push_en),
      .push_data(push_data), .rdata(rdata), .irq(irq),
      .q_full(q_full), .q_empty(q_empty)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [31:0] model_status();
      logic [31:0] s = '0;
      s[31] = (mq.size() == DEPTH);
      s[30] = (mq.size() == 0);
      return s;
   endfunction

   function automatic logic [31:0] model_cfg();
      logic [31:0] c = '0;
      c[0] = m_en;
      c[4] = (mq.size() != 0);
      return c;
   endfunction

   // expected read value from the pre-cycle model state
   function automatic logic [31:0] model_read(input logic [7:0] o, output string tag);
      logic [31:0] v;
      if (o[7:4] == 4'h8) begin
         v = (mq.size() == 0) ? SENT : mq[0];
         tag = (mq.size() == 0) ? "R3 empty pop" : "R2 R11 pop order";
      end else if (o[7:2] == 6'h24) begin
         v = (mq.size() == 0) ? SENT : mq[0];
         tag = (mq.size() == 0) ? "R5 drained peek" : "R4 peek";
      end else if (o[7:2] == 6'h26) begin
         v = model_status(); tag = "R1 status";
      end else if (o[7:2] == 6'h27) begin
         v = model_cfg(); tag = "R6 config";
      end else begin
         v = '0; tag = "R9 zero offset";
      end
      return v;
   endfunction

   // called at a falling edge: drive, advance one clock, check at next falling edge
   task automatic cyc(input logic rd, input logic wr, input logic [ADDR_W-1:0] a,
                      input logic [31:0] wd, input logic ps, input logic [31:0] pd);
      logic [31:0] exp_rd;
      string       tag;
      logic [7:0]  o;
      o = a[7:0];
      exp_rd = model_read(o, tag);
      if (rd && ps && o[7:4] == 4'h8) tag = {tag, " R10 pop+push"};
      rd_en = rd; wr_en = wr; reg_addr = a; wdata = wd; push_en = ps; push_data = pd;
      if (rd && o[7:4] == 4'h8 && mq.size() != 0) void'(mq.pop_front());
      if (wr && o[7:2] == 6'h27) m_en = wd[0];
      if (ps) mq.push_back(pd);
      @(posedge clk);
      @(negedge clk);
      rd_en = 0; wr_en = 0; push_en = 0;
      if (rd) chk(tag, rdata, exp_rd);
      chk("R1 full flag", {31'b0, q_full}, {31'b0, mq.size() == DEPTH});
      chk("R1 empty flag", {31'b0, q_empty}, {31'b0, mq.size() == 0});
      chk("R7 irq", {31'b0, irq}, {31'b0, m_en && mq.size() != 0});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED_2024));
      rst_n = 0; rd_en = 0; wr_en = 0; push_en = 0;
      reg_addr = '0; wdata = '0; push_data = '0;
      m_en = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R8 reset state
      chk("R8 empty after reset", {31'b0, q_empty}, 32'd1);
      chk("R8 full after reset", {31'b0, q_full}, 32'd0);
      chk("R8 irq after reset", {31'b0, irq}, 32'd0);
      cyc(1, 0, 16'h0098, 0, 0, 0);
      chk("R8 status word", rdata, 32'h4000_0000);
      cyc(1, 0, 16'h009C, 0, 0, 0);
      chk("R8 config word", rdata, 32'h0);
      cyc(1, 0, 16'h0090, 0, 0, 0);
      chk("R8 peek sentinel", rdata, SENT);

      // R6 enable, then fill to full
      cyc(0, 1, 16'h009C, 32'hFFFF_FFFF, 0, 0);
      cyc(1, 0, 16'h009C, 0, 0, 0);
      chk("R6 only bit0 written", rdata, 32'h1);
      for (int i = 0; i < DEPTH; i++) cyc(0, 0, 16'h0000, 0, 1, 32'hA000_0000 + i);
      cyc(1, 0, 16'h0098, 0, 0, 0);
      chk("R1 full status", rdata, 32'h8000_0000);
      cyc(1, 0, 16'h009C, 0, 0, 0);
      chk("R7 pending set", rdata, 32'h11);
      cyc(1, 0, 16'h0090, 0, 0, 0);
      chk("R4 peek head", rdata, 32'hA000_0000);

      // R9 ignored writes and high address bits
      cyc(0, 1, 16'h0094, 32'h0, 0, 0);
      cyc(0, 1, 16'h0098, 32'h0, 0, 0);
      cyc(0, 1, 16'h0084, 32'h0, 0, 0);
      cyc(0, 1, 16'h0040, 32'h0, 0, 0);
      cyc(1, 0, 16'h0094, 0, 0, 0);
      chk("R9 sender reads 0", rdata, 32'h0);
      cyc(1, 0, 16'h009C, 0, 0, 0);
      chk("R9 stray writes kept enable", rdata, 32'h11);
      cyc(1, 0, 16'h7F90, 0, 0, 0);
      chk("R9 high bits ignored peek", rdata, 32'hA000_0000);

      // R10 pop+push at one below full
      cyc(1, 0, 16'h0080, 0, 0, 0);
      cyc(1, 0, 16'h008D, 0, 1, 32'hBEEF_0001);

      // drain; R5 peek afterwards
      while (mq.size() != 0) cyc(1, 0, 16'h0088, 0, 0, 0);
      cyc(1, 0, 16'h0090, 0, 0, 0);
      chk("R5 peek after drain", rdata, SENT);
      cyc(1, 0, 16'h008C, 0, 0, 0);
      chk("R3 empty pop sentinel", rdata, SENT);

      // R10 on empty queue
      cyc(1, 0, 16'h0080, 0, 1, 32'h1234_5678);
      chk("R10 empty pop+push sentinel", rdata, SENT);
      cyc(1, 0, 16'h0090, 0, 0, 0);
      chk("R10 pushed word kept", rdata, 32'h1234_5678);

      // R6 clear enable through aliased address
      cyc(0, 1, 16'h129C, 32'hFFFF_FFFE, 0, 0);
      cyc(1, 0, 16'h009C, 0, 0, 0);
      chk("R6 R9 enable cleared via alias", rdata, 32'h10);

      // random phase
      for (int k = 0; k < 4000; k++) begin
         logic [7:0]  o;
         logic [ADDR_W-1:0] a;
         logic        rd, wr, ps;
         int          r;
         r = $urandom_range(0, 9);
         case (r)
            0, 1, 2: o = 8'h80 | 8'($urandom_range(0, 15));
            3:       o = 8'h90;
            4:       o = 8'h94;
            5:       o = 8'h98;
            6:       o = 8'h9C;
            default: o = 8'($urandom);
         endcase
         a  = {8'($urandom), o};
         rd = ($urandom_range(0, 2) != 0);
         wr = ($urandom_range(0, 3) == 0);
         ps = (mq.size() < DEPTH) && ($urandom_range(0, 1) == 1);
         cyc(rd, wr, a, $urandom, ps, $urandom);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule